// File: doc/BRIEF.md
# Atomic and Ordered Access Alignment Checker

This block sits in a load/store pipeline beside the address stage. For every atomic or ordered (acquire/release) memory request it works out the effective address, decides whether the request must take an alignment fault, and reports the access type the fault carries. All results appear one cycle after the request strobe.

The strict rule requires an access wider than one byte to be naturally aligned to its own size. When the relaxed-alignment feature is enabled, accesses of 2, 4 or 8 bytes only have to stay within one 16-byte window. Accesses of 16 bytes must be 16-byte aligned in every mode, and single-byte accesses never fault. A configuration bit can switch the window check off for ordered accesses when the relaxed feature is enabled. Atomic accesses do not look at that bit.

The access size comes from a 2-bit code and a pair flag. The pair flag doubles the access width. An unsupported combination raises an illegal-request flag instead of a fault.

Top module: `ordacc_align_chk`

## Requirements
- R1: A 1-byte access (size_code 0, pair 0) never faults, whatever the address, class, feature enable or check-disable bit.
- R2: A 16-byte access (size_code 3 with pair 1) faults whenever the effective address is not a multiple of 16. This holds whatever the feature enable, class or check-disable bit.
- R3: With relax_en 0, an access of 2, 4 or 8 bytes faults exactly when the effective address is not a multiple of its size. The check-disable bit has no effect in this mode. The sizes are encoded as follows: size_code 1 with pair 0 is 2 bytes, size_code 2 with pair 0 is 4 bytes, size_code 3 with pair 0 is 8 bytes, and size_code 2 with pair 1 is 8 bytes.
- R4: With relax_en 1, an access of 2, 4 or 8 bytes that is subject to the check faults exactly when (effective address mod 16) + size is greater than 16.
- R5: With relax_en 1, an ordered access (acc_class 1) of 2, 4 or 8 bytes never faults while ord_nochk is 1.
- R6: An atomic access (acc_class 0) is checked in the same way whether ord_nochk is 0 or 1.
- R7: fault_addr equals base_addr plus the sign-extended imm_off, taken modulo 2^AW.
- R8: fault_store is 1 for an atomic access whatever the value of is_store. For an ordered access it equals is_store.
- R9: A pair flag of 1 with size_code 0 or 1 is illegal. It drives illegal to 1 and fault to 0.
- R10: rsp_valid is 1 in exactly the cycle after req_valid is sampled 1. fault and illegal are 0 in every other cycle. Reset clears rsp_valid, fault and illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| req_valid | input | 1 | Request strobe |
| base_addr | input | AW | Base register value |
| imm_off | input | OW | Signed immediate offset |
| size_code | input | 2 | log2 of the element size in bytes |
| pair | input | 1 | Doubles the access width |
| acc_class | input | 1 | 0 for atomic, 1 for ordered |
| is_store | input | 1 | 1 for a store, 0 for a load |
| relax_en | input | 1 | Enables the 16-byte window rule |
| ord_nochk | input | 1 | Disables the window check for ordered accesses |
| rsp_valid | output | 1 | Result valid |
| fault | output | 1 | Alignment fault |
| illegal | output | 1 | Unsupported size encoding |
| fault_addr | output | AW | Effective address of the request |
| fault_store | output | 1 | Fault access type, 1 for store |

## Verification
Every result (rsp_valid, fault, illegal, fault_addr and fault_store) is registered once. Each is therefore due at the first rising edge after the edge that samples req_valid. The bench changes inputs on falling edges and holds the strobe for one cycle. It reads the outputs on the next falling edge, half a cycle after they update. It also checks that rsp_valid has dropped one cycle later. Expected values come from a model in the bench that applies the size, window and class rules to every low-nibble address.

// File: rtl/ordacc_align_pkg.sv
package ordacc_align_pkg;

  // Access class encoding on the acc_class port
  typedef enum logic {
    CLS_ATOMIC  = 1'b0,
    CLS_ORDERED = 1'b1
  } acc_class_e;

  // log2 of the relaxed window in bytes
  localparam int unsigned WIN_LG    = 4;
  localparam int unsigned WIN_BYTES = 1 << WIN_LG;

  // Decoded size: legality and log2 of the byte count
  typedef struct packed {
    logic       legal;
    logic [2:0] lg;
  } size_info_t;

endpackage

// File: rtl/ordacc_size_dec.sv
module ordacc_size_dec
  import ordacc_align_pkg::*;
(
  input  logic [1:0]  size_code,
  input  logic        pair,
  output size_info_t  info
);

  always_comb begin
    info.legal = 1'b1;
    info.lg    = {1'b0, size_code} + {2'b00, pair};
    // pairs of bytes or halfwords are not supported
    if (pair && (size_code < 2'd2)) begin
      info.legal = 1'b0;
      info.lg    = 3'd0;
    end
  end

endmodule

// File: rtl/ordacc_ea_gen.sv
module ordacc_ea_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 12
) (
  input  logic [AW-1:0] base_addr,
  input  logic [OW-1:0] imm_off,
  output logic [AW-1:0] ea
);

  localparam int unsigned EXT = AW - OW;

  logic [AW-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT{imm_off[OW-1]}}, imm_off};
    ea      = base_addr + off_ext;
  end

endmodule

// File: rtl/ordacc_fault_eval.sv
module ordacc_fault_eval
  import ordacc_align_pkg::*;
(
  input  logic [WIN_LG-1:0] ea_lo,
  input  size_info_t        info,
  input  logic              is_ordered,
  input  logic              relax_en,
  input  logic              ord_nochk,
  output logic              fault_d,
  output logic              illegal_d
);

  localparam logic [2:0]        LG_FULL = 3'(WIN_LG);
  localparam logic [WIN_LG+1:0] WIN_LIM = (WIN_LG+2)'(WIN_BYTES);

  logic [WIN_LG:0]   nbytes;
  logic [WIN_LG:0]   mask;
  logic [WIN_LG+1:0] span;
  logic              misaligned;
  logic              crosses;

  always_comb begin
    nbytes     = {{WIN_LG{1'b0}}, 1'b1} << info.lg;
    mask       = nbytes - 1'b1;
    misaligned = |(ea_lo & mask[WIN_LG-1:0]);
    span       = {2'b00, ea_lo} + {1'b0, nbytes};
    crosses    = span > WIN_LIM;
  end

  always_comb begin
    illegal_d = 1'b0;
    fault_d   = 1'b0;
    if (!info.legal) begin
      illegal_d = 1'b1;
    end else if (info.lg == 3'd0) begin
      fault_d = 1'b0;
    end else if (info.lg == LG_FULL) begin
      fault_d = misaligned;
    end else if (!relax_en) begin
      fault_d = misaligned;
    end else if (is_ordered && ord_nochk) begin
      fault_d = 1'b0;
    end else begin
      fault_d = crosses;
    end
  end

endmodule

// File: rtl/ordacc_out_reg.sv
module ordacc_out_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          fault_d,
  input  logic          illegal_d,
  input  logic [AW-1:0] ea,
  input  logic          store_d,
  output logic          rsp_valid,
  output logic          fault,
  output logic          illegal,
  output logic [AW-1:0] fault_addr,
  output logic          fault_store
);

  logic          vld_nx, flt_nx, ill_nx;
  logic [AW-1:0] addr_nx;
  logic          st_nx;

  always_comb begin
    vld_nx  = req_valid;
    flt_nx  = req_valid & fault_d;
    ill_nx  = req_valid & illegal_d;
    addr_nx = fault_addr;
    st_nx   = fault_store;
    if (req_valid) begin
      addr_nx = ea;
      st_nx   = store_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      fault     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      rsp_valid <= vld_nx;
      fault     <= flt_nx;
      illegal   <= ill_nx;
    end
  end

  always_ff @(posedge clk) begin
    fault_addr  <= addr_nx;
    fault_store <= st_nx;
  end

  // R10: result flags only alongside a valid response
  a_r10_fault_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> rsp_valid);
  a_r10_illegal_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> rsp_valid);
  // R9: an illegal request never reports a fault
  a_r9_illegal_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !fault);

endmodule

// File: rtl/ordacc_align_chk.sv
module ordacc_align_chk
  import ordacc_align_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] base_addr,
  input  logic [OW-1:0] imm_off,
  input  logic [1:0]    size_code,
  input  logic          pair,
  input  logic          acc_class,
  input  logic          is_store,
  input  logic          relax_en,
  input  logic          ord_nochk,
  output logic          rsp_valid,
  output logic          fault,
  output logic          illegal,
  output logic [AW-1:0] fault_addr,
  output logic          fault_store
);

  size_info_t    info;
  logic [AW-1:0] ea;
  logic          is_ordered;
  logic          fault_d, illegal_d, store_d;

  always_comb begin
    is_ordered = (acc_class == CLS_ORDERED);
    // read-modify-write atomics report as stores
    store_d    = is_ordered ? is_store : 1'b1;
  end

  ordacc_size_dec u_dec (
    .size_code (size_code),
    .pair      (pair),
    .info      (info)
  );

  ordacc_ea_gen #(.AW(AW), .OW(OW)) u_ea (
    .base_addr (base_addr),
    .imm_off   (imm_off),
    .ea        (ea)
  );

  ordacc_fault_eval u_eval (
    .ea_lo      (ea[WIN_LG-1:0]),
    .info       (info),
    .is_ordered (is_ordered),
    .relax_en   (relax_en),
    .ord_nochk  (ord_nochk),
    .fault_d    (fault_d),
    .illegal_d  (illegal_d)
  );

  ordacc_out_reg #(.AW(AW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .fault_d     (fault_d),
    .illegal_d   (illegal_d),
    .ea          (ea),
    .store_d     (store_d),
    .rsp_valid   (rsp_valid),
    .fault       (fault),
    .illegal     (illegal),
    .fault_addr  (fault_addr),
    .fault_store (fault_store)
  );

  // R10: response one cycle after each strobe
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_valid_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1: single bytes never fault
  a_r1_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pair && size_code == 2'd0) |=> !fault);
  // R2: 16-byte access off a 16-byte boundary faults
  a_r2_quad_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pair && size_code == 2'd3 && ea[WIN_LG-1:0] != '0) |=> fault);
  // R3: odd halfword address faults in strict mode
  a_r3_half_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !relax_en && !pair && size_code == 2'd1 &&
     (base_addr[0] ^ imm_off[0])) |=> fault);
  // R5: ordered, relaxed, check disabled, not 16 bytes: no fault
  a_r5_ordered_nochk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && relax_en && ord_nochk && acc_class == CLS_ORDERED && !pair)
      |=> !fault);
  // R7: reported address is base plus sign-extended offset
  a_r7_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fault_addr ==
      $past(base_addr + {{(AW-OW){imm_off[OW-1]}}, imm_off}));
  // R8: atomics report as stores
  a_r8_atomic_store: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_class == CLS_ATOMIC) |=> fault_store);

endmodule

// File: tb/ordacc_align_chk_bench.sv
module ordacc_align_chk_bench;

  localparam int AW = 32;
  localparam int OW = 12;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] base_addr;
  logic [OW-1:0] imm_off;
  logic [1:0]    size_code;
  logic          pair;
  logic          acc_class;
  logic          is_store;
  logic          relax_en;
  logic          ord_nochk;
  logic          rsp_valid;
  logic          fault;
  logic          illegal;
  logic [AW-1:0] fault_addr;
  logic          fault_store;

  int checks = 0;
  int errors = 0;

  ordacc_align_chk #(.AW(AW), .OW(OW)) u_ordacc_align_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_addr(base_addr),
    .imm_off(imm_off), .size_code(size_code), .pair(pair),
    .acc_class(acc_class), .is_store(is_store), .relax_en(relax_en),
    .ord_nochk(ord_nochk), .rsp_valid(rsp_valid), .fault(fault),
    .illegal(illegal), .fault_addr(fault_addr), .fault_store(fault_store)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one strobe on a falling edge, sample at the next falling edge
  task automatic apply(input logic [AW-1:0] b, input logic [OW-1:0] o,
                       input logic [1:0] sc, input logic pr, input logic cl,
                       input logic st, input logic rx, input logic nc);
    @(negedge clk);
    req_valid = 1'b1; base_addr = b; imm_off = o; size_code = sc; pair = pr;
    acc_class = cl; is_store = st; relax_en = rx; ord_nochk = nc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic ref_fault(input int nib, input int sc, input int pr,
                                     input int cl, input int rx, input int nc);
    int nb;
    nb = 1 << (sc + pr);
    if (nb == 1) return 1'b0;
    if (nb == 16 || rx == 0) return (nib % nb) != 0;
    if (cl == 1 && nc == 1) return 1'b0;
    return (nib + nb) > 16;
  endfunction

  function automatic string ref_tag(input int sc, input int pr, input int cl,
                                    input int rx, input int nc);
    int nb;
    nb = 1 << (sc + pr);
    if (nb == 1) return "R1";
    if (nb == 16) return "R2";
    if (rx == 0) return "R3";
    if (cl == 1 && nc == 1) return "R5";
    if (cl == 0 && nc == 1) return "R6";
    return "R4";
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; base_addr = '0; imm_off = '0;
    size_code = '0; pair = 1'b0; acc_class = 1'b0; is_store = 1'b0;
    relax_en = 1'b0; ord_nochk = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset rsp_valid", AW'(rsp_valid), '0);
    check("R10 reset fault", AW'(fault), '0);
    check("R10 reset illegal", AW'(illegal), '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Sweep every low nibble, legal size, class and configuration
  task automatic t_sweep;
    int codes [5] = '{0, 1, 2, 3, 2};
    int pairs [5] = '{0, 0, 0, 0, 1};
    for (int rx = 0; rx < 2; rx++)
      for (int cl = 0; cl < 2; cl++)
        for (int nc = 0; nc < 2; nc++)
          for (int k = 0; k < 5; k++)
            for (int nib = 0; nib < 16; nib++) begin
              apply(32'h0000_4a30 | AW'(nib), '0, 2'(codes[k]), 1'(pairs[k]),
                    1'(cl), 1'b0, 1'(rx), 1'(nc));
              check({ref_tag(codes[k], pairs[k], cl, rx, nc), " fault"},
                    AW'(fault),
                    AW'(ref_fault(nib, codes[k], pairs[k], cl, rx, nc)));
              check("R10 valid", AW'(rsp_valid), 1);
              check("R9 legal", AW'(illegal), 0);
            end
    // 16-byte in every mode
    for (int nib = 0; nib < 16; nib++) begin
      apply(32'h100 | AW'(nib), '0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R2 quad", AW'(fault), AW'(nib != 0));
    end
  endtask

  // Offsets move the effective address within and across windows
  task automatic t_offset;
    apply(32'h0000_1000, 12'hffc, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 negative offset", fault_addr, 32'h0000_0ffc);
    check("R4 crossing via offset", AW'(fault), 1);
    apply(32'hffff_fff8, 12'h010, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 wrap", fault_addr, 32'h0000_0008);
    check("R4 inside window", AW'(fault), 0);
    apply(32'h0000_0003, 12'h7ff, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 max offset", fault_addr, 32'h0000_0802);
    check("R3 even halfword", AW'(fault), 0);
    apply(32'h0000_2005, 12'h800, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 min offset", fault_addr, 32'h0000_1805);
    check("R2 quad offset", AW'(fault), 1);
  endtask

  task automatic t_store_type;
    apply(32'h40, '0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 atomic load is store", AW'(fault_store), 1);
    apply(32'h40, '0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 ordered load", AW'(fault_store), 0);
    apply(32'h40, '0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 ordered store", AW'(fault_store), 1);
  endtask

  task automatic t_illegal;
    for (int sc = 0; sc < 2; sc++) begin
      apply(32'h7, '0, 2'(sc), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R9 illegal flag", AW'(illegal), 1);
      check("R9 no fault", AW'(fault), 0);
    end
  endtask

  task automatic t_timing;
    apply(32'h3, '0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 fault due", AW'(fault), 1);
    @(negedge clk);
    check("R10 valid drops", AW'(rsp_valid), 0);
    check("R10 fault drops", AW'(fault), 0);
  endtask

  initial begin
    t_reset;
    t_sweep;
    t_offset;
    t_store_type;
    t_illegal;
    t_timing;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule